// File: doc/BRIEF.md
# Banked Byte Register File with Indirect Select

This block is the byte-wide data store of a small processor core. An instruction names one of 32 locations with a 5-bit operand address. The lower half of that window (0x00 to 0x0F) always maps onto one shared global page. The upper half (0x10 to 0x1F) maps onto one of eight 16-byte banks. The top three bits of an internal 8-bit select register choose the bank. Behind the window there are 144 byte locations: 16 global and 8 x 16 banked.

The select register lives inside the block at operand address 0x04 and clears on reset. Addressing location 0x00, or raising the `indirect` input, turns the access indirect. The full select value then becomes the effective address and passes through the same bank rules. Global offsets 0x01 to 0x07, apart from the select register, are passed to an external special-function port instead of RAM. A parameter turns offset 0x07 into an ordinary RAM byte for a reduced-pin build. Reads are combinational and writes take effect on the rising clock edge.

Top module: `bank_regfile`

## Requirements
- R1: After reset the select register reads 0x00 at operand address 0x04.
- R2: A write to operand address 0x04 loads the select register on the next edge, raises no port strobe, and is read back at 0x04.
- R3: Direct offsets 0x08 to 0x0F reach the same global byte whatever the select register's bits 7:5 hold.
- R4: Direct offsets 0x10 to 0x1F reach bank number select[7:5] at offset bits 3:0, so each bank keeps its own data (select 0x90 gives bank 4, select 0x30 gives bank 1).
- R5: An access at operand address 0x00 uses the select register as the effective address. Select bit 4 = 1 reaches bank select[7:5] at select[3:0]. Select bit 4 = 0 reaches global byte select[3:0].
- R6: With `indirect` high the operand address is ignored and the access behaves as one at 0x00.
- R7: Global offsets 0x01, 0x02, 0x03, 0x05, 0x06 (and 0x07 when SPARE_07 = 0) drive `sfr_addr` with offset bits 2:0. `sfr_wdata` carries the write data, `sfr_we` pulses with `wr_en`, and read data comes from `sfr_rdata`.
- R8: With SPARE_07 = 1, offset 0x07 is a RAM byte that stores and returns data and never raises `sfr_we`.
- R9: With `wr_en` low, nothing is stored.
- R10: An indirect access whose effective offset is 0x00 reads 0x00, and a write to it changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_addr | input | 5 | Direct operand address |
| indirect | input | 1 | Forces an indirect access through the select register |
| wr_en | input | 1 | Write enable for the addressed location |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| sfr_addr | output | 3 | Special-function register index |
| sfr_wdata | output | 8 | Write data towards the special-function registers |
| sfr_we | output | 1 | Special-function write strobe |
| sfr_rdata | input | 8 | Read data from the special-function registers |

## Verification
The bench builds two instances on shared inputs. One uses the default SPARE_07 = 0, where offset 0x07 is a port location and a write there pulses `sfr_we`. The other uses SPARE_07 = 1, where the same write must be stored and read back without any strobe. Running both side by side covers each variant of the 0x07 decode within a single run. All other checks apply to both builds alike: bank switching, global aliasing, both indirect forms and the null indirect target.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

  localparam int DATA_W    = 8;
  localparam int OP_AW     = 5;
  localparam int BANK_W    = 3;
  localparam int HALF_W    = 4;
  localparam int SFR_AW    = 3;
  localparam int HALF_SZ   = 1 << HALF_W;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int RAM_WORDS = (1 + NUM_BANKS) * HALF_SZ;
  localparam int IDX_W     = $clog2(RAM_WORDS);

  typedef enum logic [1:0] {
    LOC_RAM  = 2'd0,
    LOC_SFR  = 2'd1,
    LOC_FSEL = 2'd2,
    LOC_NULL = 2'd3
  } loc_kind_e;

  typedef struct packed {
    loc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [SFR_AW-1:0]  sfr;
  } loc_t;

endpackage

// File: rtl/brf_reset_sync.sv
module brf_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/brf_select_reg.sv
module brf_select_reg
  import bank_regfile_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sel_q
);

  logic [W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (load) begin
      sel_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sel_q == $past(load_val));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));

endmodule

// File: rtl/brf_addr_decode.sv
module brf_addr_decode
  import bank_regfile_pkg::*;
#(
  parameter int         OPW      = OP_AW,
  parameter int         BW       = BANK_W,
  parameter int         HW       = HALF_W,
  parameter int         SW       = SFR_AW,
  parameter int         IW       = IDX_W,
  parameter logic [SW-1:0] SEL_OFF = 3'd4,
  parameter bit         SPARE_07 = 1'b0
) (
  input  logic [OPW-1:0]    op_addr,
  input  logic              indirect,
  input  logic [BW+OPW-1:0] sel_val,
  output loc_t              loc
);

  localparam logic [SW-1:0] LAST_SFR = '1;

  logic           use_sel;
  logic [OPW-1:0] eff_off;
  logic [BW-1:0]  bank;
  logic           banked;
  logic           upper_global;
  logic [HW-1:0]  half_off;
  logic [SW-1:0]  low_off;

  always_comb begin
    use_sel      = indirect || (op_addr == '0);
    eff_off      = use_sel ? sel_val[OPW-1:0] : op_addr;
    bank         = sel_val[BW+OPW-1:OPW];
    banked       = eff_off[OPW-1];
    half_off     = eff_off[HW-1:0];
    upper_global = eff_off[HW-1];
    low_off      = eff_off[SW-1:0];
  end

  always_comb begin
    loc.kind = LOC_NULL;
    loc.idx  = '0;
    loc.sfr  = low_off;
    if (banked) begin
      loc.kind = LOC_RAM;
      loc.idx  = IW'({1'b0, bank, half_off}) + IW'(1 << HW);
    end else if (upper_global) begin
      loc.kind = LOC_RAM;
      loc.idx  = IW'(half_off);
    end else if (low_off == '0) begin
      loc.kind = LOC_NULL;
    end else if (low_off == SEL_OFF) begin
      loc.kind = LOC_FSEL;
    end else if (SPARE_07 && (low_off == LAST_SFR)) begin
      loc.kind = LOC_RAM;
      loc.idx  = IW'(half_off);
    end else begin
      loc.kind = LOC_SFR;
    end
  end

endmodule

// File: rtl/brf_ram.sv
module brf_ram
  import bank_regfile_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int WORDS = RAM_WORDS,
  parameter int IW    = IDX_W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter bit SPARE_07 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_AW-1:0]  op_addr,
  input  logic              indirect,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [SFR_AW-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  output logic              sfr_we,
  input  logic [DATA_W-1:0] sfr_rdata
);

  localparam int SEL_W = BANK_W + OP_AW;
  localparam logic [SFR_AW-1:0] SEL_OFF = SFR_AW'(4);

  logic              rst_n_int;
  loc_t              loc;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_load;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rd;

  brf_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  brf_addr_decode #(
    .OPW      (OP_AW),
    .BW       (BANK_W),
    .HW       (HALF_W),
    .SW       (SFR_AW),
    .IW       (IDX_W),
    .SEL_OFF  (SEL_OFF),
    .SPARE_07 (SPARE_07)
  ) u_dec (
    .op_addr  (op_addr),
    .indirect (indirect),
    .sel_val  (sel_q),
    .loc      (loc)
  );

  always_comb begin
    sel_load = wr_en && (loc.kind == LOC_FSEL);
    ram_we   = wr_en && (loc.kind == LOC_RAM);
    sfr_we   = wr_en && (loc.kind == LOC_SFR);
  end

  brf_select_reg #(.W(SEL_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (sel_load),
    .load_val (wr_data),
    .sel_q    (sel_q)
  );

  brf_ram #(
    .DW    (DATA_W),
    .WORDS (RAM_WORDS),
    .IW    (IDX_W)
  ) u_ram (
    .clk   (clk),
    .wr_en (ram_we),
    .idx   (loc.idx),
    .wdata (wr_data),
    .rdata (ram_rd)
  );

  always_comb begin
    unique case (loc.kind)
      LOC_RAM:  rd_data = ram_rd;
      LOC_SFR:  rd_data = sfr_rdata;
      LOC_FSEL: rd_data = sel_q;
      default:  rd_data = '0;
    endcase
  end

  assign sfr_addr  = loc.sfr;
  assign sfr_wdata = wr_data;

  // R1: select register is clear on the first cycle out of reset
  p_sel_clear_r1: assert property (@(posedge clk)
    $rose(rst_n_int) |-> sel_q == '0);

  // R3: direct lower-half offsets never land in a banked location
  p_low_global_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!indirect && op_addr != '0 && !op_addr[OP_AW-1] && loc.kind == LOC_RAM)
      |-> loc.idx < IDX_W'(HALF_SZ));

  // R4: direct upper-half offsets land in the bank chosen by the select bits
  p_bank_pick_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!indirect && op_addr[OP_AW-1])
      |-> (loc.kind == LOC_RAM) &&
          (loc.idx / IDX_W'(HALF_SZ) == IDX_W'(sel_q[SEL_W-1:OP_AW]) + 1));

  // R7: the port strobe only ever accompanies a write request
  p_sfr_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    sfr_we |-> wr_en && !sel_load);

  // R10: the null indirect target reads zero and raises no strobe
  p_null_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (loc.kind == LOC_NULL) |-> (rd_data == '0) && !sfr_we);

endmodule

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
module bank_regfile_test;

  typedef struct {
    bit         spare;
    bit         chk_rd;
    logic [7:0] exp_rd;
    bit         chk_sfr;
    bit         exp_we;
    logic [2:0] exp_addr;
    logic [7:0] exp_wd;
    string      tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [4:0] op_addr;
  logic       indirect;
  logic       wr_en;
  logic [7:0] wr_data;

  logic [7:0] rd_a, rd_b;
  logic [2:0] sa_a, sa_b;
  logic [7:0] swd_a, swd_b;
  logic       swe_a, swe_b;
  logic [7:0] srd_a, srd_b;

  int checks;
  int fails;
  bit done;
  item_t q[$];

  assign srd_a = 8'hA0 ^ {5'b0, sa_a};
  assign srd_b = 8'hA0 ^ {5'b0, sa_b};

  bank_regfile #(.SPARE_07(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .indirect(indirect),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a), .sfr_addr(sa_a),
    .sfr_wdata(swd_a), .sfr_we(swe_a), .sfr_rdata(srd_a)
  );

  bank_regfile #(.SPARE_07(1'b1)) uut_spare (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .indirect(indirect),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b), .sfr_addr(sa_b),
    .sfr_wdata(swd_b), .sfr_we(swe_b), .sfr_rdata(srd_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic item_t mk(bit sp, bit cr, logic [7:0] er, bit cs, bit ew,
                               logic [2:0] ea, logic [7:0] ewd, string tg);
    item_t it;
    it.spare = sp; it.chk_rd = cr; it.exp_rd = er; it.chk_sfr = cs;
    it.exp_we = ew; it.exp_addr = ea; it.exp_wd = ewd; it.tag = tg;
    return it;
  endfunction

  task automatic step(input logic [4:0] a, input logic ind, input logic we,
                      input logic [7:0] wd, input item_t it);
    @(posedge clk);
    #1;
    op_addr = a; indirect = ind; wr_en = we; wr_data = wd;
    q.push_back(it);
  endtask

  task automatic rd(input logic [4:0] a, input logic ind, input bit sp,
                    input logic [7:0] e, input string tg);
    step(a, ind, 1'b0, 8'h00, mk(sp, 1, e, 0, 0, 0, 0, tg));
  endtask

  task automatic wr(input logic [4:0] a, input logic ind, input logic [7:0] d);
    step(a, ind, 1'b1, d, mk(0, 0, 0, 0, 0, 0, 0, ""));
  endtask

  task automatic wr_sfr(input logic [4:0] a, input logic ind, input logic [7:0] d,
                        input bit sp, input bit ew, input logic [2:0] ea,
                        input string tg);
    step(a, ind, 1'b1, d, mk(sp, 0, 0, 1, ew, ea, d, tg));
  endtask

  // monitor: pops one expected item per cycle, mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] ard;
        logic       awe;
        logic [2:0] aad;
        logic [7:0] awd;
        it  = q.pop_front();
        ard = it.spare ? rd_b  : rd_a;
        awe = it.spare ? swe_b : swe_a;
        aad = it.spare ? sa_b  : sa_a;
        awd = it.spare ? swd_b : swd_a;
        if (it.chk_rd) begin
          checks++;
          if (ard !== it.exp_rd) begin
            fails++;
            $display("FAIL %s rd_data actual %h expected %h", it.tag, ard, it.exp_rd);
          end
        end
        if (it.chk_sfr) begin
          checks++;
          if (awe !== it.exp_we ||
              (it.exp_we && (aad !== it.exp_addr || awd !== it.exp_wd))) begin
            fails++;
            $display("FAIL %s sfr we/addr/wdata actual %b/%h/%h expected %b/%h/%h",
                     it.tag, awe, aad, awd, it.exp_we, it.exp_addr, it.exp_wd);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; op_addr = '0; indirect = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    rd(5'h04, 0, 0, 8'h00, "R1");
    rd(5'h04, 0, 1, 8'h00, "R1");
    wr_sfr(5'h04, 0, 8'h90, 0, 0, 3'd0, "R2");
    rd(5'h04, 0, 0, 8'h90, "R2");

    wr(5'h10, 0, 8'h64);                 // bank 4, offset 0
    wr(5'h04, 0, 8'h30);
    wr(5'h10, 0, 8'h11);                 // bank 1, offset 0
    rd(5'h10, 0, 0, 8'h11, "R4 bank1");
    wr(5'h04, 0, 8'h90);
    rd(5'h10, 0, 0, 8'h64, "R4 bank4");
    rd(5'h10, 0, 1, 8'h64, "R4 bank4 spare");

    wr(5'h08, 0, 8'h5A);
    wr(5'h04, 0, 8'hE0);
    rd(5'h08, 0, 0, 8'h5A, "R3");
    rd(5'h08, 0, 1, 8'h5A, "R3 spare");

    wr(5'h04, 0, 8'h9F);
    wr(5'h00, 0, 8'h77);                 // indirect into bank 4 offset 0xF
    wr(5'h04, 0, 8'h80);
    rd(5'h1F, 0, 0, 8'h77, "R5 indirect write");
    wr(5'h04, 0, 8'h90);
    rd(5'h00, 0, 0, 8'h64, "R5 indirect read");
    rd(5'h15, 1, 0, 8'h64, "R6");
    wr(5'h04, 0, 8'hE8);
    rd(5'h00, 0, 0, 8'h5A, "R5 indirect global");

    wr_sfr(5'h02, 0, 8'h3C, 0, 1, 3'd2, "R7");
    rd(5'h05, 0, 0, 8'hA5, "R7");
    rd(5'h07, 0, 0, 8'hA7, "R7");
    wr_sfr(5'h07, 0, 8'h4B, 0, 1, 3'd7, "R7");

    wr_sfr(5'h07, 0, 8'hC3, 1, 0, 3'd0, "R8");
    rd(5'h07, 0, 1, 8'hC3, "R8");

    wr(5'h04, 0, 8'h90);
    step(5'h10, 0, 1'b0, 8'hFF, mk(0, 0, 0, 0, 0, 0, 0, ""));
    rd(5'h10, 0, 0, 8'h64, "R9");

    wr(5'h04, 0, 8'h20);
    wr_sfr(5'h00, 0, 8'hEE, 0, 0, 3'd0, "R10");
    rd(5'h00, 0, 0, 8'h00, "R10");
    rd(5'h04, 0, 0, 8'h20, "R10");
    rd(5'h10, 0, 0, 8'h11, "R10");
    rd(5'h08, 0, 0, 8'h5A, "R10");

    step(5'h04, 0, 1'b0, 8'h00, mk(0, 0, 0, 0, 0, 0, 0, ""));
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule